// File: doc/BRIEF.md
# SPI Dual-Format Register Access Slave

This block is the SPI slave front end of a register file. It receives commands from an SPI master in mode 0, most significant bit first, and turns them into single-cycle read and write requests on a simple parallel register bus. It supports two command formats, and bit 7 of the first byte selects between them. A short command is two bytes long and reaches a 64-entry space. A long command is three bytes long and reaches a 1024-entry space. Each long address is mapped to one of eight memory regions, and the region code is reported next to the address.

SCK, chip select and MOSI are sampled in the system clock domain through synchronizer chains. Each SCK phase must therefore last at least eight system clocks.

A read request is issued as soon as the address bits are complete. This gives the register target time to answer before the final byte slot, where the read value is shifted out on MISO. Chip select released after exactly one complete byte is reported as a framing error. Any release of chip select returns the decoder to its starting state.

The decoder is a five-state machine:
- `ST_HDR` waits for the first byte. It moves to `ST_SHORT_DATA` when bit 7 is 0 and to `ST_LONG_ADDR` when bit 7 is 1.
- `ST_SHORT_DATA` takes the short data byte and moves to `ST_DRAIN`.
- `ST_LONG_ADDR` takes the second address byte and moves to `ST_LONG_DATA`.
- `ST_LONG_DATA` takes the long data byte and moves to `ST_DRAIN`.
- `ST_DRAIN` ignores every further byte.
- A chip-select release moves every state back to `ST_HDR`.

Top module: `spi_dual_fmt_regif`

## Requirements
- R1: Bit 7 of the first byte of a chip-select window selects the format. A value of 0 selects short (two bytes) and 1 selects long (three bytes).
- R2: Short command fields: the address is bits 6:1 of byte 1 and the write flag is bit 0 (1 = write). A short write pulses `bus_wr_req` with that address, `bus_wdata` equal to byte 2, and `bus_long` = 0.
- R3: Long command fields: bytes 1 and 2 form a 16-bit word with byte 1 in the upper half. The address is word bits 14:5 and the write flag is word bit 4. Word bits 3:0 are ignored. A long write pulses `bus_wr_req` with `bus_wdata` equal to byte 3 and `bus_long` = 1.
- R4: A read pulses `bus_rd_req` once, after byte 1 (short) or byte 2 (long). `bus_rdata` must be valid during the clock after that pulse. That value is shifted out MSB first on MISO in the final byte slot, and MISO is 0 in every other slot. MOSI is sampled on the SCK rising edge and MISO changes after the falling edge.
- R5: For long accesses `bus_region` is set as follows:
  - 0 for 0x000–0x07F
  - 1 for 0x080–0x0FF
  - 2 for 0x100–0x17F
  - 3 for 0x180–0x1FF
  - 4 for 0x200–0x27F
  - 5 for 0x280–0x2BF
  - 6 for 0x2C0–0x2FF
  - 7 for 0x300–0x3FF
- R6: For short accesses `bus_region` is 0.
- R7: When chip select rises after exactly one complete byte, `frame_err` pulses for one clock. A byte count of 0, 2, 3 or more raises no error, and trailing partial bits are not counted. A long command released after two bytes is dropped without a write.
- R8: A chip-select rise clears the bit counter, the shift state and the decoder state, so the next window decodes normally even after a partial byte.
- R9: Bytes that follow a complete command in the same window cause no request and return 0 on MISO.
- R10: `cmd_done` pulses for one clock when each complete command ends, in the same cycle as `bus_wr_req` for writes. It never pulses for a dropped command.
- R11: `bus_rd_req` and `bus_wr_req` are one-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI clock from the master, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| bus_rd_req | output | 1 | Single-cycle read request |
| bus_wr_req | output | 1 | Single-cycle write request |
| bus_addr | output | 10 | Register address (short addresses zero-extended) |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid the clock after `bus_rd_req` |
| bus_long | output | 1 | 1 when the access uses the long format |
| bus_region | output | 3 | Region code of a long address |
| cmd_done | output | 1 | Pulse at the end of a complete command |
| frame_err | output | 1 | Pulse on a framing error |

## Verification
The bench builds the block with the default two-stage synchronizer and drives SCK with a 16-clock period. At that rate the whole short space can be swept with a write followed by a read-back at every address. The long space is covered by every region boundary address plus a coarse stride, and the region code is checked against an arithmetic range table. Further windows end after one byte, after two long bytes, or after a partial byte, and some carry trailing bytes, to reach the framing and drain behaviour.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

    localparam int BYTE_W         = 8;
    localparam int SHORT_AW       = 6;
    localparam int LONG_AW        = 10;
    localparam int REGION_W       = 3;
    localparam int BIT_CNT_W      = $clog2(BYTE_W);

    localparam int FMT_BIT        = 7;
    localparam int SHORT_WR_BIT   = 0;
    localparam int SHORT_ADDR_LSB = 1;
    localparam int LONG_WR_BIT    = 4;
    localparam int LONG_ADDR_LSB  = 5;

    typedef enum logic [REGION_W-1:0] {
        RG_TX_NORMAL = 3'd0,
        RG_TX_BEACON = 3'd1,
        RG_TX_SLOT_A = 3'd2,
        RG_TX_SLOT_B = 3'd3,
        RG_CTRL      = 3'd4,
        RG_KEYS      = 3'd5,
        RG_RSVD      = 3'd6,
        RG_RX        = 3'd7
    } region_e;

    localparam logic [LONG_AW-1:0] LIM_BEACON = 10'h080;
    localparam logic [LONG_AW-1:0] LIM_SLOT_A = 10'h100;
    localparam logic [LONG_AW-1:0] LIM_SLOT_B = 10'h180;
    localparam logic [LONG_AW-1:0] LIM_CTRL   = 10'h200;
    localparam logic [LONG_AW-1:0] LIM_KEYS   = 10'h280;
    localparam logic [LONG_AW-1:0] LIM_RSVD   = 10'h2C0;
    localparam logic [LONG_AW-1:0] LIM_RX     = 10'h300;

    typedef enum logic [2:0] {
        ST_HDR        = 3'd0,
        ST_SHORT_DATA = 3'd1,
        ST_LONG_ADDR  = 3'd2,
        ST_LONG_DATA  = 3'd3,
        ST_DRAIN      = 3'd4
    } dec_state_e;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[g]}};
            end else begin
                chain <= {chain[STAGES-2:0], d[g]};
            end
        end

        assign q[g] = chain[STAGES-1];
    end

endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine
    import spi_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    input  logic [BYTE_W-1:0] tx_load,
    output logic              miso,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              cs_release
);

    logic                 sck_q;
    logic                 cs_n_q;
    logic [BIT_CNT_W-1:0] bit_cnt;
    logic [BYTE_W-1:0]    rx_sr;
    logic [BYTE_W-1:0]    tx_sr;
    logic                 sck_rise;
    logic                 sck_fall;

    assign sck_rise   = sck_s & ~sck_q & ~cs_n_s;
    assign sck_fall   = ~sck_s & sck_q & ~cs_n_s;
    assign cs_release = cs_n_s & ~cs_n_q;
    assign miso       = tx_sr[BYTE_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q  <= 1'b0;
            cs_n_q <= 1'b1;
        end else begin
            sck_q  <= sck_s;
            cs_n_q <= cs_n_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sr    <= '0;
            tx_sr    <= '0;
            rx_valid <= 1'b0;
            rx_byte  <= '0;
        end else if (cs_n_s) begin
            bit_cnt  <= '0;
            rx_sr    <= '0;
            tx_sr    <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (sck_rise) begin
                rx_sr   <= {rx_sr[BYTE_W-2:0], mosi_s};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == BIT_CNT_W'(BYTE_W-1)) begin
                    rx_valid <= 1'b1;
                    rx_byte  <= {rx_sr[BYTE_W-2:0], mosi_s};
                end
            end
            if (sck_fall) begin
                if (bit_cnt == '0) begin
                    tx_sr <= tx_load;
                end else begin
                    tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    a_r8_cnt_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (bit_cnt == '0));

    a_r9_miso_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !miso);

endmodule

// File: rtl/addr_region_map.sv
module addr_region_map
    import spi_regif_pkg::*;
(
    input  logic [LONG_AW-1:0] addr,
    output region_e            region
);

    always_comb begin
        if (addr < LIM_BEACON) begin
            region = RG_TX_NORMAL;
        end else if (addr < LIM_SLOT_A) begin
            region = RG_TX_BEACON;
        end else if (addr < LIM_SLOT_B) begin
            region = RG_TX_SLOT_A;
        end else if (addr < LIM_CTRL) begin
            region = RG_TX_SLOT_B;
        end else if (addr < LIM_KEYS) begin
            region = RG_CTRL;
        end else if (addr < LIM_RSVD) begin
            region = RG_KEYS;
        end else if (addr < LIM_RX) begin
            region = RG_RSVD;
        end else begin
            region = RG_RX;
        end
    end

endmodule

// File: rtl/cmd_decoder.sv
module cmd_decoder
    import spi_regif_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_valid,
    input  logic [BYTE_W-1:0]  rx_byte,
    input  logic               cs_release,
    input  logic [BYTE_W-1:0]  bus_rdata,
    output logic [BYTE_W-1:0]  tx_byte,
    output logic               rd_req,
    output logic               wr_req,
    output logic [LONG_AW-1:0] addr,
    output logic [BYTE_W-1:0]  wdata,
    output logic               is_long,
    output region_e            region,
    output logic               done,
    output logic               frame_err
);

    dec_state_e          state_q, state_d;
    logic [BYTE_W-1:0]   hdr_q;
    logic                wr_flag_q;
    logic                rd_pend_q;
    logic [2*BYTE_W-1:0] long_word;
    logic [LONG_AW-1:0]  long_addr;
    region_e             long_region;

    assign long_word = {hdr_q, rx_byte};
    assign long_addr = long_word[LONG_ADDR_LSB +: LONG_AW];

    addr_region_map u_region (
        .addr   (long_addr),
        .region (long_region)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HDR:        if (rx_valid) state_d = rx_byte[FMT_BIT] ? ST_LONG_ADDR : ST_SHORT_DATA;
            ST_SHORT_DATA: if (rx_valid) state_d = ST_DRAIN;
            ST_LONG_ADDR:  if (rx_valid) state_d = ST_LONG_DATA;
            ST_LONG_DATA:  if (rx_valid) state_d = ST_DRAIN;
            ST_DRAIN:      state_d = ST_DRAIN;
        endcase
        if (cs_release) begin
            state_d = ST_HDR;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HDR;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_req    <= 1'b0;
            wr_req    <= 1'b0;
            done      <= 1'b0;
            frame_err <= 1'b0;
            rd_pend_q <= 1'b0;
            addr      <= '0;
            wdata     <= '0;
            is_long   <= 1'b0;
            region    <= RG_TX_NORMAL;
            hdr_q     <= '0;
            wr_flag_q <= 1'b0;
            tx_byte   <= '0;
        end else begin
            rd_req    <= 1'b0;
            wr_req    <= 1'b0;
            done      <= 1'b0;
            frame_err <= 1'b0;
            rd_pend_q <= rd_req;
            if (rd_pend_q) begin
                tx_byte <= bus_rdata;
            end
            if (cs_release) begin
                frame_err <= (state_q == ST_SHORT_DATA) || (state_q == ST_LONG_ADDR);
                tx_byte   <= '0;
                wr_flag_q <= 1'b0;
                rd_pend_q <= 1'b0;
            end else if (rx_valid) begin
                unique case (state_q)
                    ST_HDR: begin
                        hdr_q <= rx_byte;
                        if (!rx_byte[FMT_BIT]) begin
                            addr      <= LONG_AW'(rx_byte[SHORT_ADDR_LSB +: SHORT_AW]);
                            is_long   <= 1'b0;
                            region    <= RG_TX_NORMAL;
                            wr_flag_q <= rx_byte[SHORT_WR_BIT];
                            rd_req    <= !rx_byte[SHORT_WR_BIT];
                        end
                    end
                    ST_LONG_ADDR: begin
                        addr      <= long_addr;
                        is_long   <= 1'b1;
                        region    <= long_region;
                        wr_flag_q <= long_word[LONG_WR_BIT];
                        rd_req    <= !long_word[LONG_WR_BIT];
                    end
                    ST_SHORT_DATA, ST_LONG_DATA: begin
                        wr_req  <= wr_flag_q;
                        wdata   <= rx_byte;
                        done    <= 1'b1;
                        tx_byte <= '0;
                    end
                    ST_DRAIN: begin
                    end
                endcase
            end
        end
    end

    a_r11_req_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));

    a_r11_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_err_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> $past(cs_release));

    a_r7_err_not_done: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_err && done));

    a_r4_rdata_captured: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pend_q && !cs_release) |=> (tx_byte == $past(bus_rdata)));

endmodule

// File: rtl/spi_dual_fmt_regif.sv
module spi_dual_fmt_regif
    import spi_regif_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spi_sck,
    input  logic        spi_cs_n,
    input  logic        spi_mosi,
    output logic        spi_miso,
    output logic        bus_rd_req,
    output logic        bus_wr_req,
    output logic [9:0]  bus_addr,
    output logic [7:0]  bus_wdata,
    input  logic [7:0]  bus_rdata,
    output logic        bus_long,
    output logic [2:0]  bus_region,
    output logic        cmd_done,
    output logic        frame_err
);

    localparam int PIN_W = 3;

    logic [PIN_W-1:0]  pins_s;
    logic              rx_valid;
    logic [BYTE_W-1:0] rx_byte;
    logic              cs_release;
    logic [BYTE_W-1:0] tx_byte;
    region_e           region;

    pin_sync #(
        .WIDTH   (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_mosi, spi_cs_n, spi_sck}),
        .q     (pins_s)
    );

    spi_byte_engine u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_s      (pins_s[0]),
        .cs_n_s     (pins_s[1]),
        .mosi_s     (pins_s[2]),
        .tx_load    (tx_byte),
        .miso       (spi_miso),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .cs_release (cs_release)
    );

    cmd_decoder u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .cs_release (cs_release),
        .bus_rdata  (bus_rdata),
        .tx_byte    (tx_byte),
        .rd_req     (bus_rd_req),
        .wr_req     (bus_wr_req),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .is_long    (bus_long),
        .region     (region),
        .done       (cmd_done),
        .frame_err  (frame_err)
    );

    assign bus_region = region;

endmodule

// File: tb/sim_spi_dual_fmt_regif.sv
module sim_spi_dual_fmt_regif;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int GAP        = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic       mosi = 1'b0;
    logic       miso;
    logic       rd_req, wr_req, is_long, done, ferr;
    logic [9:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata = 8'h00;
    logic [2:0] region;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_dual_fmt_regif u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_sck    (sck),
        .spi_cs_n   (cs_n),
        .spi_mosi   (mosi),
        .spi_miso   (miso),
        .bus_rd_req (rd_req),
        .bus_wr_req (wr_req),
        .bus_addr   (addr),
        .bus_wdata  (wdata),
        .bus_rdata  (rdata),
        .bus_long   (is_long),
        .bus_region (region),
        .cmd_done   (done),
        .frame_err  (ferr)
    );

    logic [7:0] smem [64];
    logic [7:0] lmem [1024];
    int rd_cnt = 0, wr_cnt = 0, done_cnt = 0, ferr_cnt = 0, both_cnt = 0, done_wr_mis = 0;
    logic [9:0] last_addr;
    logic [7:0] last_wdata;
    logic       last_long;
    logic [2:0] last_region;

    initial begin
        for (int i = 0; i < 64; i++) smem[i] = 8'h00;
        for (int i = 0; i < 1024; i++) lmem[i] = 8'h00;
    end

    always @(posedge clk) begin
        if (rst_n) begin
            if (rd_req) begin
                rd_cnt++;
                rdata <= is_long ? lmem[addr] : smem[addr[5:0]];
                last_addr = addr; last_long = is_long; last_region = region;
            end
            if (wr_req) begin
                wr_cnt++;
                if (is_long) lmem[addr] = wdata; else smem[addr[5:0]] = wdata;
                last_addr = addr; last_wdata = wdata; last_long = is_long; last_region = region;
            end
            if (rd_req && wr_req) both_cnt++;
            if (done) done_cnt++;
            if (wr_req && !done) done_wr_mis++;
            if (ferr) ferr_cnt++;
        end
    end

    logic [7:0] tx_buf [6];
    logic [7:0] rx_buf [6];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic spi_xfer(input int nb, input int xbits);
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nb + (xbits > 0 ? 1 : 0); i++) begin
            for (int b = 7; b >= 0; b--) begin
                if (i < nb || (7 - b) < xbits) begin
                    mosi = tx_buf[i][b];
                    repeat (HALF) @(negedge clk);
                    rx_buf[i][b] = miso;
                    sck = 1'b1;
                    repeat (HALF) @(negedge clk);
                    sck = 1'b0;
                end
            end
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (GAP) @(negedge clk);
    endtask

    function automatic logic [7:0] sval(input int a);
        return 8'((a * 3 + 8'h15) & 8'hFF);
    endfunction

    function automatic logic [7:0] lval(input int a);
        return 8'((a ^ (a >> 3) ^ 8'h5C) & 8'hFF);
    endfunction

    function automatic int exp_region(input int a);
        if (a < 'h080) return 0;
        if (a < 'h100) return 1;
        if (a < 'h180) return 2;
        if (a < 'h200) return 3;
        if (a < 'h280) return 4;
        if (a < 'h2C0) return 5;
        if (a < 'h300) return 6;
        return 7;
    endfunction

    task automatic long_access(input int a, input bit wr);
        logic [15:0] w;
        int wc, rc, dc;
        w = 16'h8000 | 16'(a << 5) | (wr ? 16'h0010 : 16'h0000) | 16'h000A;
        tx_buf[0] = w[15:8]; tx_buf[1] = w[7:0]; tx_buf[2] = wr ? lval(a) : 8'h00;
        wc = wr_cnt; rc = rd_cnt; dc = done_cnt;
        spi_xfer(3, 0);
        chk(last_addr == 10'(a), "R3 long address", last_addr, a);
        chk(last_long == 1'b1, "R1 long format flag", last_long, 1);
        chk(int'(last_region) == exp_region(a), "R5 region code", last_region, exp_region(a));
        chk(done_cnt == dc + 1, "R10 done on long command", done_cnt - dc, 1);
        if (wr) begin
            chk(wr_cnt == wc + 1 && rc == rd_cnt, "R3 one long write", wr_cnt - wc, 1);
            chk(last_wdata == lval(a), "R3 long write data", last_wdata, lval(a));
        end else begin
            chk(rd_cnt == rc + 1 && wc == wr_cnt, "R4 one long read", rd_cnt - rc, 1);
            chk(rx_buf[2] == lval(a), "R4 long read data on MISO", rx_buf[2], lval(a));
            chk(rx_buf[0] == 8'h00 && rx_buf[1] == 8'h00, "R4 MISO zero in address slots", {rx_buf[0], rx_buf[1]}, 0);
        end
    endtask

    initial begin
        int longs [41];
        int wc, rc, dc, fc;
        longs[0] = 'h000; longs[1] = 'h07F; longs[2] = 'h080; longs[3] = 'h0FF;
        longs[4] = 'h100; longs[5] = 'h17F; longs[6] = 'h180; longs[7] = 'h1FF;
        longs[8] = 'h200; longs[9] = 'h27F; longs[10] = 'h280; longs[11] = 'h2BF;
        longs[12] = 'h2C0; longs[13] = 'h2FF; longs[14] = 'h300; longs[15] = 'h3FF;
        for (int k = 0; k < 25; k++) longs[16 + k] = 5 + 41 * k;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!rd_req && !wr_req && !done && !ferr, "R11 idle outputs after reset", {rd_req, wr_req, done, ferr}, 0);
        chk(miso == 1'b0, "R9 MISO low after reset", miso, 0);

        // R2 / R6: short write sweep over the whole 64-entry space
        for (int a = 0; a < 64; a++) begin
            tx_buf[0] = 8'((a << 1) | 1); tx_buf[1] = sval(a);
            wc = wr_cnt; dc = done_cnt;
            spi_xfer(2, 0);
            chk(wr_cnt == wc + 1 && last_addr == 10'(a), "R2 short write address", last_addr, a);
            chk(last_wdata == sval(a) && last_long == 1'b0, "R2 short write data", last_wdata, sval(a));
            chk(last_region == 3'd0, "R6 short region zero", last_region, 0);
            chk(done_cnt == dc + 1, "R10 done on short write", done_cnt - dc, 1);
        end
        // R4: short read-back sweep
        for (int a = 0; a < 64; a++) begin
            tx_buf[0] = 8'(a << 1); tx_buf[1] = 8'h00;
            rc = rd_cnt; wc = wr_cnt;
            spi_xfer(2, 0);
            chk(rd_cnt == rc + 1 && wr_cnt == wc && last_addr == 10'(a), "R4 short read request", last_addr, a);
            chk(rx_buf[1] == sval(a), "R4 short read data on MISO", rx_buf[1], sval(a));
            chk(rx_buf[0] == 8'h00, "R4 MISO zero in header slot", rx_buf[0], 0);
        end

        // R3 / R5: long writes then reads at region boundaries and a stride
        for (int i = 0; i < 41; i++) long_access(longs[i], 1'b1);
        for (int i = 0; i < 41; i++) long_access(longs[i], 1'b0);

        // R7: release after one byte
        fc = ferr_cnt; wc = wr_cnt; dc = done_cnt;
        tx_buf[0] = 8'h0B;
        spi_xfer(1, 0);
        chk(ferr_cnt == fc + 1, "R7 error after one byte", ferr_cnt - fc, 1);
        chk(wr_cnt == wc && done_cnt == dc, "R10 no done on dropped command", done_cnt - dc, 0);

        // R7: one byte plus partial bits still counts as one byte
        fc = ferr_cnt;
        tx_buf[0] = 8'h85; tx_buf[1] = 8'hFF;
        spi_xfer(1, 5);
        chk(ferr_cnt == fc + 1, "R7 error with trailing partial bits", ferr_cnt - fc, 1);

        // R7: long write dropped after two bytes, no error
        fc = ferr_cnt; wc = wr_cnt; dc = done_cnt;
        tx_buf[0] = 8'h80; tx_buf[1] = 8'h30;
        spi_xfer(2, 0);
        chk(ferr_cnt == fc, "R7 no error after two long bytes", ferr_cnt - fc, 0);
        chk(wr_cnt == wc && done_cnt == dc, "R7 two-byte long write dropped", wr_cnt - wc, 0);

        // R8: partial byte only, then a clean short write
        fc = ferr_cnt;
        tx_buf[0] = 8'hFF;
        spi_xfer(0, 3);
        chk(ferr_cnt == fc, "R7 no error on zero complete bytes", ferr_cnt - fc, 0);
        wc = wr_cnt;
        tx_buf[0] = 8'h7F; tx_buf[1] = 8'hC3;
        spi_xfer(2, 0);
        chk(wr_cnt == wc + 1 && last_addr == 10'h03F && last_wdata == 8'hC3, "R8 fresh decode after partial", last_addr, 'h3F);

        // R9: trailing bytes after a short write
        wc = wr_cnt; rc = rd_cnt; fc = ferr_cnt; dc = done_cnt;
        tx_buf[0] = 8'h05; tx_buf[1] = 8'h11; tx_buf[2] = 8'h07; tx_buf[3] = 8'h99;
        spi_xfer(4, 0);
        chk(wr_cnt == wc + 1 && rd_cnt == rc && last_addr == 10'h002 && last_wdata == 8'h11, "R9 only first command executes", wr_cnt - wc, 1);
        chk(ferr_cnt == fc && done_cnt == dc + 1, "R9 trailing bytes raise nothing", ferr_cnt - fc, 0);
        // R9: trailing bytes after a short read return zero
        tx_buf[0] = 8'h04; tx_buf[1] = 8'h00; tx_buf[2] = 8'h00; tx_buf[3] = 8'h00;
        rc = rd_cnt;
        spi_xfer(4, 0);
        chk(rx_buf[1] == 8'h11 && rd_cnt == rc + 1, "R4 read of fresh write", rx_buf[1], 'h11);
        chk(rx_buf[2] == 8'h00 && rx_buf[3] == 8'h00, "R9 MISO zero after command", {rx_buf[2], rx_buf[3]}, 0);

        chk(both_cnt == 0, "R11 read and write never together", both_cnt, 0);
        chk(done_wr_mis == 0, "R10 done aligned with write", done_wr_mis, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule